// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit decodes and executes the saturating arithmetic group of a 32-bit RISC core. The group has five forms: add of two registers, add of a sign-extended 5-bit immediate, subtract, reverse subtract, and subtract of a sign-extended 16-bit immediate that arrives in a second instruction halfword. The unit receives the first halfword, the second halfword, and the two register values that the register file has read for the halfword's two register fields. It returns a 32-bit result, the destination register index, a write strobe, and the condition flags.

When a signed result does not fit in 32 bits, the unit clamps it to the most positive or the most negative value and sets the overflow flag. It also sets a sticky saturation flag, which only reset clears. A halfword outside the group produces no write and leaves every flag as it was. Fetch, the register file and hazard handling lie outside this block.

Top module: `satarith_unit`

## Requirements
- R1: Register add, first halfword bits [10:5] = 6'b000110, computes sat(B + A), where B is the register named by bits [15:11] (also the destination) and A is the register named by bits [4:0].
- R2: Immediate add, bits [10:5] = 6'b010001, computes sat(B + imm5), with imm5 in bits [4:0] sign-extended to 32 bits.
- R3: Subtract, bits [10:5] = 6'b000101, computes sat(B - A).
- R4: Reverse subtract, bits [10:5] = 6'b000100, computes sat(A - B).
- R5: Immediate subtract, bits [10:5] = 6'b110011, computes sat(A - imm16), with imm16 the whole second halfword, sign-extended.
- R6: On positive signed overflow the result is 32'h7FFF_FFFF, on negative signed overflow it is 32'h8000_0000, and OV is 1 exactly when such a clamp happened.
- R7: The sticky flag SAT becomes 1 on a clamp and otherwise keeps its value; only reset clears it.
- R8: S is bit 31 and Z is the all-zero test of the clamped result; CY is the carry out of an add or the unsigned borrow (first operand below second) of a subtract, taken from the unclamped operation.
- R9: A register field equal to 0 reads as zero whatever the input value; a destination of 0 keeps the write strobe low, while the flags still update.
- R10: With the valid input low or an opcode outside the five forms, the write strobe stays low and the flags and the result hold their values.
- R11: Result, destination, write strobe and flags change on the clock edge that samples the valid input; the write strobe is high for that one cycle only.
- R12: After reset the result, destination, write strobe and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| hw0_i | input | 16 | First instruction halfword |
| hw1_i | input | 16 | Second instruction halfword (immediate subtract only) |
| rs_a_i | input | 32 | Value of the register named by bits [4:0] |
| rs_b_i | input | 32 | Value of the register named by bits [15:11] |
| result_o | output | 32 | Clamped result |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write strobe for the destination |
| cy_o | output | 1 | Carry / borrow flag |
| ov_o | output | 1 | Overflow (clamp) flag |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The hardest situation to reach is the sticky flag's memory: it shows only after a clamping operation is followed by ordinary ones, and a fault that clears it on any operation is invisible unless later non-clamping and illegal halfwords are checked with SAT still expected high. The bench therefore clamps in both directions through add, subtract and the two-halfword form, then runs non-clamping and out-of-group halfwords and checks that SAT stays set while OV drops. Operand inputs carry nonzero junk whenever a field names register 0, so zero forcing is seen at the result.

// File: rtl/satarith_pkg.sv
package satarith_pkg;

  localparam int XLEN    = 32;
  localparam int HW_W    = 16;
  localparam int REG_W   = 5;
  localparam int OPC_W   = 6;
  localparam int IMM_S_W = 5;
  localparam int IMM_L_W = 16;

  localparam int OPC_LO  = REG_W;
  localparam int OPC_HI  = REG_W + OPC_W - 1;
  localparam int DST_LO  = REG_W + OPC_W;
  localparam int DST_HI  = HW_W - 1;

  localparam logic [OPC_W-1:0] OPC_ADD_R = 6'b000110;
  localparam logic [OPC_W-1:0] OPC_ADD_I = 6'b010001;
  localparam logic [OPC_W-1:0] OPC_SUB   = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_SUBR  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_SUB_I = 6'b110011;

  localparam logic [XLEN-1:0] SAT_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] SAT_MIN = {1'b1, {(XLEN-1){1'b0}}};

  typedef enum logic [2:0] {
    K_NONE, K_ADD_R, K_ADD_I, K_SUB, K_SUBR, K_SUB_I
  } op_kind_e;

  typedef struct packed {
    logic [XLEN-1:0] res;
    logic            cy;
    logic            ov;
  } alu_out_t;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
    logic sat;
  } flags_t;

  function automatic op_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_ADD_R: classify = K_ADD_R;
      OPC_ADD_I: classify = K_ADD_I;
      OPC_SUB:   classify = K_SUB;
      OPC_SUBR:  classify = K_SUBR;
      OPC_SUB_I: classify = K_SUB_I;
      default:   classify = K_NONE;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext_short(input logic [IMM_S_W-1:0] v);
    sext_short = {{(XLEN-IMM_S_W){v[IMM_S_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] sext_long(input logic [IMM_L_W-1:0] v);
    sext_long = {{(XLEN-IMM_L_W){v[IMM_L_W-1]}}, v};
  endfunction

  // Raw add or subtract with carry/borrow and signed overflow, then clamp.
  function automatic alu_out_t sat_addsub(input logic [XLEN-1:0] x,
                                          input logic [XLEN-1:0] y,
                                          input logic            sub);
    logic [XLEN:0]   wide;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] y_eff;
    alu_out_t        o;
    wide  = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
    raw   = wide[XLEN-1:0];
    y_eff = sub ? ~y : y;
    o.cy  = wide[XLEN];
    o.ov  = (x[XLEN-1] == y_eff[XLEN-1]) && (raw[XLEN-1] != x[XLEN-1]);
    o.res = o.ov ? (x[XLEN-1] ? SAT_MIN : SAT_MAX) : raw;
    return o;
  endfunction

endpackage

// File: rtl/satarith_decode.sv
module satarith_decode
  import satarith_pkg::*;
(
  input  logic [HW_W-1:0]  hw0,
  input  logic [HW_W-1:0]  hw1,
  input  logic [XLEN-1:0]  rs_a,
  input  logic [XLEN-1:0]  rs_b,
  output op_kind_e         kind,
  output logic             legal,
  output logic             is_sub,
  output logic [XLEN-1:0]  op_x,
  output logic [XLEN-1:0]  op_y,
  output logic [REG_W-1:0] dest
);

  logic [REG_W-1:0] idx_a;
  logic [XLEN-1:0]  val_a;
  logic [XLEN-1:0]  val_b;

  assign idx_a = hw0[REG_W-1:0];
  assign dest  = hw0[DST_HI:DST_LO];
  assign kind  = classify(hw0[OPC_HI:OPC_LO]);
  assign legal = (kind != K_NONE);

  // Register 0 is hard-wired to zero.
  assign val_a = (idx_a == '0) ? '0 : rs_a;
  assign val_b = (dest  == '0) ? '0 : rs_b;

  always_comb begin
    op_x   = val_b;
    op_y   = val_a;
    is_sub = 1'b0;
    case (kind)
      K_ADD_R: begin op_x = val_b; op_y = val_a; is_sub = 1'b0; end
      K_ADD_I: begin op_x = val_b; op_y = sext_short(hw0[IMM_S_W-1:0]); is_sub = 1'b0; end
      K_SUB:   begin op_x = val_b; op_y = val_a; is_sub = 1'b1; end
      K_SUBR:  begin op_x = val_a; op_y = val_b; is_sub = 1'b1; end
      K_SUB_I: begin op_x = val_a; op_y = sext_long(hw1[IMM_L_W-1:0]); is_sub = 1'b1; end
      default: begin op_x = '0; op_y = '0; is_sub = 1'b0; end
    endcase
  end

endmodule

// File: rtl/satarith_alu.sv
module satarith_alu
  import satarith_pkg::*;
(
  input  logic [XLEN-1:0] op_x,
  input  logic [XLEN-1:0] op_y,
  input  logic            is_sub,
  output alu_out_t        alu,
  output logic            clamp
);

  assign alu   = sat_addsub(op_x, op_y, is_sub);
  assign clamp = alu.ov;

endmodule

// File: rtl/satarith_flags.sv
module satarith_flags
  import satarith_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  alu_out_t        alu,
  output flags_t          flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (upd) begin
      flags.cy  <= alu.cy;
      flags.ov  <= alu.ov;
      flags.s   <= alu.res[XLEN-1];
      flags.z   <= (alu.res == '0);
      flags.sat <= flags.sat | alu.ov;
    end
  end

endmodule

// File: rtl/satarith_unit.sv
module satarith_unit
  import satarith_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [HW_W-1:0]   hw0_i,
  input  logic [HW_W-1:0]   hw1_i,
  input  logic [XLEN-1:0]   rs_a_i,
  input  logic [XLEN-1:0]   rs_b_i,
  output logic [XLEN-1:0]   result_o,
  output logic [REG_W-1:0]  dest_o,
  output logic              wr_en_o,
  output logic              cy_o,
  output logic              ov_o,
  output logic              s_o,
  output logic              z_o,
  output logic              sat_o
);

  op_kind_e         kind;
  logic             legal;
  logic             is_sub;
  logic [XLEN-1:0]  op_x;
  logic [XLEN-1:0]  op_y;
  logic [REG_W-1:0] dest_d;
  alu_out_t         alu;
  flags_t           flags;

  // Named events for the checker.
  logic exec_fire;
  logic clamp_fire;
  logic write_fire;
  logic clamp_raw;

  satarith_decode u_decode (
    .hw0(hw0_i), .hw1(hw1_i), .rs_a(rs_a_i), .rs_b(rs_b_i),
    .kind(kind), .legal(legal), .is_sub(is_sub),
    .op_x(op_x), .op_y(op_y), .dest(dest_d)
  );

  satarith_alu u_alu (
    .op_x(op_x), .op_y(op_y), .is_sub(is_sub), .alu(alu), .clamp(clamp_raw)
  );

  assign exec_fire  = valid_i && legal;
  assign clamp_fire = exec_fire && clamp_raw;
  assign write_fire = exec_fire && (dest_d != '0);

  satarith_flags u_flags (
    .clk(clk), .rst_n(rst_n), .upd(exec_fire), .alu(alu), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      dest_o   <= '0;
      wr_en_o  <= 1'b0;
    end else begin
      wr_en_o <= write_fire;
      if (exec_fire) begin
        result_o <= alu.res;
        dest_o   <= dest_d;
      end
    end
  end

  assign cy_o  = flags.cy;
  assign ov_o  = flags.ov;
  assign s_o   = flags.s;
  assign z_o   = flags.z;
  assign sat_o = flags.sat;

endmodule

// File: rtl/satarith_checks.sv
module satarith_checks
  import satarith_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              exec_fire,
  input logic              clamp_fire,
  input logic              write_fire,
  input logic [XLEN-1:0]   result_o,
  input logic [REG_W-1:0]  dest_o,
  input logic              wr_en_o,
  input logic              cy_o,
  input logic              ov_o,
  input logic              s_o,
  input logic              z_o,
  input logic              sat_o
);

  assert_clamp_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_o |-> (result_o == SAT_MAX || result_o == SAT_MIN));

  assert_clamp_sets_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_fire |=> (ov_o && sat_o));

  assert_sat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |=> sat_o);

  assert_sz_follow_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> (s_o == result_o[XLEN-1]) && (z_o == (result_o == '0)));

  assert_no_zero_dest_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (dest_o != '0));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> (!wr_en_o && $stable({cy_o, ov_o, s_o, z_o, sat_o}) && $stable(result_o)));

  assert_write_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    write_fire |=> wr_en_o);

endmodule

bind satarith_unit satarith_checks u_checks (
  .clk(clk), .rst_n(rst_n),
  .exec_fire(exec_fire), .clamp_fire(clamp_fire), .write_fire(write_fire),
  .result_o(result_o), .dest_o(dest_o), .wr_en_o(wr_en_o),
  .cy_o(cy_o), .ov_o(ov_o), .s_o(s_o), .z_o(z_o), .sat_o(sat_o)
);

// File: tb/satarith_unit_bench.sv
`timescale 1ns/1ps
module satarith_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] hw0_i = '0;
  logic [15:0] hw1_i = '0;
  logic [31:0] rs_a_i = '0;
  logic [31:0] rs_b_i = '0;
  logic [31:0] result_o;
  logic [4:0]  dest_o;
  logic        wr_en_o, cy_o, ov_o, s_o, z_o, sat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_sat = 1'b0;

  always #10 clk = ~clk;

  satarith_unit u_satarith_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .hw0_i(hw0_i), .hw1_i(hw1_i),
    .rs_a_i(rs_a_i), .rs_b_i(rs_b_i), .result_o(result_o), .dest_o(dest_o),
    .wr_en_o(wr_en_o), .cy_o(cy_o), .ov_o(ov_o), .s_o(s_o), .z_o(z_o), .sat_o(sat_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [4:0] b, input logic [5:0] opc, input logic [4:0] a);
    return {b, opc, a};
  endfunction

  // Independent model using 64-bit signed arithmetic.
  task automatic model(input logic [15:0] h0, input logic [15:0] h1,
                       input logic [31:0] ra, input logic [31:0] rb,
                       output bit legal, output logic [31:0] res,
                       output bit cy, output bit ov);
    longint sx, sy, sr;
    logic [31:0] ux, uy;
    bit sub;
    logic [31:0] a = (h0[4:0] == 0) ? 32'd0 : ra;
    logic [31:0] b = (h0[15:11] == 0) ? 32'd0 : rb;
    legal = 1; sub = 0; ux = 0; uy = 0;
    case (h0[10:5])
      6'b000110: begin ux = b; uy = a; end
      6'b010001: begin ux = b; uy = {{27{h0[4]}}, h0[4:0]}; end
      6'b000101: begin ux = b; uy = a; sub = 1; end
      6'b000100: begin ux = a; uy = b; sub = 1; end
      6'b110011: begin ux = a; uy = {{16{h1[15]}}, h1}; sub = 1; end
      default: legal = 0;
    endcase
    sx = longint'($signed(ux));
    sy = longint'($signed(uy));
    sr = sub ? sx - sy : sx + sy;
    cy = sub ? (ux < uy) : ((64'(ux) + 64'(uy)) > 64'hFFFF_FFFF);
    ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    if (sr > 64'sd2147483647) res = 32'h7FFF_FFFF;
    else if (sr < -64'sd2147483648) res = 32'h8000_0000;
    else res = sr[31:0];
  endtask

  // Drive one instruction on a falling edge; outputs checked one falling edge later.
  task automatic issue(input logic [15:0] h0, input logic [15:0] h1,
                       input logic [31:0] ra, input logic [31:0] rb);
    @(negedge clk);
    hw0_i = h0; hw1_i = h1; rs_a_i = ra; rs_b_i = rb; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input logic [15:0] h0, input logic [15:0] h1,
                               input logic [31:0] ra, input logic [31:0] rb);
    bit legal, cy, ov;
    logic [31:0] res;
    model(h0, h1, ra, rb, legal, res, cy, ov);
    exp_sat = exp_sat | ov;
    issue(h0, h1, ra, rb);
    chk({tag, " result"}, result_o, res);
    chk({tag, " dest"}, 32'(dest_o), 32'(h0[15:11]));
    chk({tag, " wr_en"}, 32'(wr_en_o), 32'(h0[15:11] != 0));
    chk({tag, " cy"}, 32'(cy_o), 32'(cy));
    chk({tag, " ov"}, 32'(ov_o), 32'(ov));
    chk({tag, " s"}, 32'(s_o), 32'(res[31]));
    chk({tag, " z"}, 32'(z_o), 32'(res == 0));
    chk({tag, " sat"}, 32'(sat_o), 32'(exp_sat));
  endtask

  task automatic t_reset;
    chk("R12 result", result_o, 0);
    chk("R12 dest", 32'(dest_o), 0);
    chk("R12 flags", 32'({wr_en_o, cy_o, ov_o, s_o, z_o, sat_o}), 0);
  endtask

  task automatic t_add_reg;
    run_and_check("R1 add", enc(5'd3, 6'b000110, 5'd4), 16'h0, 32'd7, 32'd5);
    chk("R1 value 12", result_o, 32'd12);
    run_and_check("R8 add carry", enc(5'd3, 6'b000110, 5'd4), 16'h0, 32'hFFFF_FFFF, 32'd2);
    chk("R8 carry set", 32'(cy_o), 1);
    chk("R8 sum 1", result_o, 32'd1);
  endtask

  task automatic t_add_imm;
    run_and_check("R2 addi", enc(5'd6, 6'b010001, 5'b11111), 16'h0, 32'h1234_5678, 32'd10);
    chk("R2 10+(-1)", result_o, 32'd9);
    run_and_check("R2 addi pos", enc(5'd6, 6'b010001, 5'b01111), 16'h0, 32'h0, 32'hFFFF_FFF0);
    chk("R2 -16+15", result_o, 32'hFFFF_FFFF);
  endtask

  task automatic t_clamps;
    run_and_check("R6 add pos", enc(5'd2, 6'b000110, 5'd1), 16'h0, 32'd1, 32'h7FFF_FFFF);
    chk("R6 max", result_o, 32'h7FFF_FFFF);
    chk("R7 sat set", 32'(sat_o), 1);
    run_and_check("R7 after", enc(5'd2, 6'b000110, 5'd1), 16'h0, 32'd1, 32'd1);
    chk("R7 ov clear", 32'(ov_o), 0);
    chk("R7 sat kept", 32'(sat_o), 1);
    run_and_check("R6 sub neg", enc(5'd2, 6'b000101, 5'd1), 16'h0, 32'd1, 32'h8000_0000);
    chk("R6 min", result_o, 32'h8000_0000);
    run_and_check("R6 subi pos", enc(5'd9, 6'b110011, 5'd8), 16'h8000, 32'h7FFF_FFF0, 32'd0);
    chk("R6 subi max", result_o, 32'h7FFF_FFFF);
  endtask

  task automatic t_sub_forms;
    run_and_check("R3 sub", enc(5'd10, 6'b000101, 5'd11), 16'h0, 32'd5, 32'd3);
    chk("R3 3-5", result_o, 32'hFFFF_FFFE);
    chk("R8 borrow", 32'(cy_o), 1);
    run_and_check("R4 subr", enc(5'd10, 6'b000100, 5'd11), 16'h0, 32'd10, 32'd3);
    chk("R4 10-3", result_o, 32'd7);
    run_and_check("R5 subi", enc(5'd12, 6'b110011, 5'd13), 16'hFFFF, 32'd100, 32'hDEAD_BEEF);
    chk("R5 100-(-1)", result_o, 32'd101);
    run_and_check("R8 zero", enc(5'd10, 6'b000101, 5'd11), 16'h0, 32'd42, 32'd42);
    chk("R8 z set", 32'(z_o), 1);
  endtask

  task automatic t_reg_zero;
    run_and_check("R9 src0", enc(5'd4, 6'b000110, 5'd0), 16'h0, 32'h5555_5555, 32'd20);
    chk("R9 src0 value", result_o, 32'd20);
    run_and_check("R9 dst0", enc(5'd0, 6'b000100, 5'd7), 16'h0, 32'd9, 32'hAAAA_AAAA);
    chk("R9 dst0 no write", 32'(wr_en_o), 0);
    chk("R9 dst0 value", result_o, 32'd9);
  endtask

  task automatic t_idle_illegal;
    logic [31:0] r0;
    logic [5:0]  f0;
    r0 = result_o;
    f0 = {cy_o, ov_o, s_o, z_o, sat_o, 1'b0};
    issue(enc(5'd5, 6'b111111, 5'd6), 16'h0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    chk("R10 illegal wr", 32'(wr_en_o), 0);
    chk("R10 illegal result", result_o, r0);
    chk("R10 illegal flags", 32'({cy_o, ov_o, s_o, z_o, sat_o, 1'b0}), 32'(f0));
    @(negedge clk);
    hw0_i = enc(5'd5, 6'b000110, 5'd6); rs_a_i = 32'h7FFF_FFFF; rs_b_i = 32'd1;
    @(negedge clk);
    chk("R10 valid low", result_o, r0);
    chk("R10 valid low wr", 32'(wr_en_o), 0);
  endtask

  task automatic t_timing;
    run_and_check("R11 op", enc(5'd8, 6'b000110, 5'd9), 16'h0, 32'd1, 32'd2);
    chk("R11 strobe high", 32'(wr_en_o), 1);
    @(negedge clk);
    chk("R11 strobe drop", 32'(wr_en_o), 0);
    chk("R11 result held", result_o, 32'd3);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_add_reg;
    t_add_imm;
    t_sub_forms;
    t_clamps;
    t_reg_zero;
    t_idle_illegal;
    t_timing;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run;
  end

endmodule